// File: doc/BRIEF.md
# Microcontroller Data-Space Address Router

This block sits between an 8-bit microcontroller core and its data storage. Every data-memory access from the core arrives as an access type, an address, write data and read/write enables. The block works out which store the access belongs to: a working register in one of four banks, the 256-byte internal RAM, the special function register (SFR) bus, or the 1 KB auxiliary RAM. It then performs the access. It owns both RAM arrays. SFR contents live elsewhere and are reached through a request bus whose read data the router hands back to the core.

The same numeric address can mean different things depending on how it is reached. A direct access to the upper half of internal address space goes to the SFRs, while an indirect access to the same address lands in upper internal RAM. The 8-bit MOVX pointer sees only the first 256 auxiliary bytes. A 16-bit MOVX beyond the auxiliary RAM is treated as off-chip. No such bus exists, so a read returns whatever the port-0 pins currently show and a write is dropped. The external strobes never move: the address-latch strobe stays low and the program-store strobe stays high.

Top module: `dspace_router`

## Requirements
- R1: With access type 0 (register), `addr[2:0]` selects register n, and the access reaches internal RAM byte `bankSel*8 + n`.
- R2: Internal RAM bytes 0 to 127 are shared by access type 1 (direct, `addr[7:0]`) and access type 2 (register-indirect, `addr[7:0]`). Data written by one is read back by the other.
- R3: An indirect access (type 2) to addresses 128 to 255 reaches upper internal RAM. It does not raise an SFR request.
- R4: A direct access (type 1) with `addr[7]` set raises `sfrReq` in the same cycle. It presents `sfrAddr = addr[7:0]` and `sfrWrData = wrData`, with `sfrWr` high for a write. It does not touch internal RAM. No other access type raises `sfrReq`.
- R5: A MOVX through the 8-bit pointer (type 3) reaches auxiliary byte `addr[7:0]`. This is the same byte a 16-bit MOVX reaches at that address, and bytes 256 and above cannot be reached this way.
- R6: A MOVX through the 16-bit pointer (type 4) with `addr` below 1024 reaches auxiliary byte `addr[9:0]`.
- R7: A type 4 access with `addr` of 1024 or more is off-chip. A read returns the value of `port0In` seen in the request cycle. A write changes no storage, including the auxiliary byte at `addr mod 1024`.
- R8: Auxiliary RAM and internal RAM are separate stores. An auxiliary write leaves the internal byte with the same index unchanged.
- R9: `aleOut` is always 0 and `psenOut` is always 1.
- R10: A read with a defined access type (0 to 4) gives `rdData` and a one-cycle `rdValid` pulse on the clock edge after the request. `rdValid` is low in any cycle that follows no read. Writes take effect on the rising edge of the request cycle.
- R11: The read data of a direct SFR read is taken from `sfrRdData` in the request cycle and appears on `rdData` one cycle later.
- R12: A synchronous reset (`rst` high at a clock edge) clears `rdData` to 0 and `rdValid` to 0.
- R13: Access types 5 to 7 are ignored. They write nothing, produce no `rdValid` and raise no `sfrReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| accType | input | 3 | Access type: 0 register, 1 direct, 2 indirect, 3 MOVX 8-bit, 4 MOVX 16-bit |
| addr | input | 16 | Access address (register index in bits 2:0 for type 0) |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read request |
| wrEn | input | 1 | Write request |
| bankSel | input | 2 | Active register bank |
| port0In | input | 8 | Live port-0 pin value |
| sfrRdData | input | 8 | Read data returned by the SFR bus |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | Read data valid pulse |
| sfrReq | output | 1 | SFR bus request |
| sfrWr | output | 1 | SFR bus write strobe |
| sfrAddr | output | 8 | SFR bus address |
| sfrWrData | output | 8 | SFR bus write data |
| aleOut | output | 1 | Address-latch strobe pin (held low) |
| psenOut | output | 1 | Program-store strobe pin (held high) |

## Verification
The SFR request outputs depend only on the current inputs. The bench therefore checks them a nanosecond after it drives a request, before any clock edge. RAM writes commit on the edge that ends the request cycle. Read data and `rdValid` are due on that same edge, so each read is checked at the falling edge that follows it, and `rdValid` is checked to be low again at the next falling edge. Inputs change only on falling edges, so no check depends on the order of processes at a rising edge.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [2:0] {
    ACC_REG      = 3'd0,
    ACC_DIRECT   = 3'd1,
    ACC_INDIRECT = 3'd2,
    ACC_MOVX8    = 3'd3,
    ACC_MOVX16   = 3'd4
  } accKind_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_IRAM,
    SRC_XRAM,
    SRC_SFR,
    SRC_PORT
  } rdSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   iramWe;
    logic   xramWe;
    logic   rdStrobe;
    rdSrc_e src;
  } dsrCtl_t;

endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IRAM_DEPTH  = 256,
  parameter int XRAM_DEPTH  = 1024,
  parameter int REGS_PER_BK = 8,
  localparam int IRAM_AW    = $clog2(IRAM_DEPTH),
  localparam int XRAM_AW    = $clog2(XRAM_DEPTH),
  localparam int REG_IDX_W  = $clog2(REGS_PER_BK),
  localparam int PTR8_W     = 8
) (
  input  logic [2:0]         accType,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [1:0]         bankSel,
  output dsrCtl_t            ctl,
  output logic [IRAM_AW-1:0] iramAddr,
  output logic [XRAM_AW-1:0] xramAddr,
  output logic               sfrSel
);

  logic iramHit;
  logic xramHit;
  logic sfrHit;
  logic portHit;
  logic known;

  always_comb begin
    iramHit  = 1'b0;
    xramHit  = 1'b0;
    sfrHit   = 1'b0;
    portHit  = 1'b0;
    known    = 1'b1;
    iramAddr = '0;
    xramAddr = '0;
    case (accType)
      ACC_REG: begin
        iramHit  = 1'b1;
        iramAddr = IRAM_AW'({bankSel, addr[REG_IDX_W-1:0]});
      end
      ACC_DIRECT: begin
        // upper half of direct space belongs to the SFRs
        if (addr[IRAM_AW-1]) sfrHit = 1'b1;
        else                 iramHit = 1'b1;
        iramAddr = addr[IRAM_AW-1:0];
      end
      ACC_INDIRECT: begin
        iramHit  = 1'b1;
        iramAddr = addr[IRAM_AW-1:0];
      end
      ACC_MOVX8: begin
        xramHit  = 1'b1;
        xramAddr = XRAM_AW'(addr[PTR8_W-1:0]);
      end
      ACC_MOVX16: begin
        if (32'(addr) < XRAM_DEPTH) xramHit = 1'b1;
        else                        portHit = 1'b1;
        xramAddr = addr[XRAM_AW-1:0];
      end
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    ctl.iramWe   = iramHit & wrEn;
    ctl.xramWe   = xramHit & wrEn;
    ctl.rdStrobe = known & rdEn;
    if (iramHit)      ctl.src = SRC_IRAM;
    else if (xramHit) ctl.src = SRC_XRAM;
    else if (sfrHit)  ctl.src = SRC_SFR;
    else if (portHit) ctl.src = SRC_PORT;
    else              ctl.src = SRC_NONE;
  end

  assign sfrSel = sfrHit;

endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath
  import dsr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IRAM_DEPTH  = 256,
  parameter int XRAM_DEPTH  = 1024,
  localparam int IRAM_AW    = $clog2(IRAM_DEPTH),
  localparam int XRAM_AW    = $clog2(XRAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  dsrCtl_t            ctl,
  input  logic [IRAM_AW-1:0] iramAddr,
  input  logic [XRAM_AW-1:0] xramAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  sfrRdData,
  input  logic [DATA_W-1:0]  port0In,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid
);

  logic [DATA_W-1:0] iram [IRAM_DEPTH];
  logic [DATA_W-1:0] xram [XRAM_DEPTH];
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (ctl.iramWe) iram[iramAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (ctl.xramWe) xram[xramAddr] <= wrData;
  end

  always_comb begin
    case (ctl.src)
      SRC_IRAM: rdMux = iram[iramAddr];
      SRC_XRAM: rdMux = xram[xramAddr];
      SRC_SFR:  rdMux = sfrRdData;
      SRC_PORT: rdMux = port0In;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.rdStrobe;
      if (ctl.rdStrobe) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dsr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int IRAM_DEPTH  = 256,
  parameter int XRAM_DEPTH  = 1024,
  parameter int REGS_PER_BK = 8,
  localparam int IRAM_AW    = $clog2(IRAM_DEPTH),
  localparam int XRAM_AW    = $clog2(XRAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        accType,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [1:0]        bankSel,
  input  logic [DATA_W-1:0] port0In,
  input  logic [DATA_W-1:0] sfrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              sfrReq,
  output logic              sfrWr,
  output logic [7:0]        sfrAddr,
  output logic [DATA_W-1:0] sfrWrData,
  output logic              aleOut,
  output logic              psenOut
);

  dsrCtl_t            ctl;
  logic [IRAM_AW-1:0] iramAddr;
  logic [XRAM_AW-1:0] xramAddr;
  logic               sfrSel;

  dsr_ctrl #(
    .ADDR_W(ADDR_W), .IRAM_DEPTH(IRAM_DEPTH),
    .XRAM_DEPTH(XRAM_DEPTH), .REGS_PER_BK(REGS_PER_BK)
  ) u_ctrl (
    .accType(accType), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .bankSel(bankSel), .ctl(ctl), .iramAddr(iramAddr),
    .xramAddr(xramAddr), .sfrSel(sfrSel)
  );

  dsr_datapath #(
    .DATA_W(DATA_W), .IRAM_DEPTH(IRAM_DEPTH), .XRAM_DEPTH(XRAM_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .iramAddr(iramAddr),
    .xramAddr(xramAddr), .wrData(wrData), .sfrRdData(sfrRdData),
    .port0In(port0In), .rdData(rdData), .rdValid(rdValid)
  );

  assign sfrReq    = sfrSel & (rdEn | wrEn);
  assign sfrWr     = sfrSel & wrEn;
  assign sfrAddr   = addr[7:0];
  assign sfrWrData = wrData;

  // no external bus cycles are ever run
  assign aleOut  = 1'b0;
  assign psenOut = 1'b1;

endmodule

// File: rtl/dsr_checks.sv
module dsr_checks (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  accType,
  input logic [15:0] addr,
  input logic        rdEn,
  input logic        wrEn,
  input logic [7:0]  port0In,
  input logic [7:0]  sfrRdData,
  input logic [7:0]  rdData,
  input logic        rdValid,
  input logic        sfrReq,
  input logic        sfrWr,
  input logic        aleOut,
  input logic        psenOut
);

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (aleOut == 1'b0 && psenOut == 1'b1)); // R9

  AST_RDVALID_DUE: assert property (@(posedge clk) disable iff (rst)
    (rdEn && accType <= 3'd4) |=> rdValid); // R10

  AST_RDVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> !rdValid); // R10

  AST_SFR_DIRECT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (accType == 3'd1 && addr[7] && (rdEn || wrEn)) |-> sfrReq); // R4

  AST_SFR_ONLY_DIRECT: assert property (@(posedge clk) disable iff (rst)
    sfrReq |-> (accType == 3'd1 && addr[7])); // R4

  AST_SFR_READ_PASS: assert property (@(posedge clk) disable iff (rst)
    (sfrReq && !sfrWr && rdEn) |=> rdData == $past(sfrRdData)); // R11

  AST_OFFCHIP_READ: assert property (@(posedge clk) disable iff (rst)
    (rdEn && accType == 3'd4 && addr >= 16'd1024) |=> rdData == $past(port0In)); // R7

  AST_UNUSED_TYPE: assert property (@(posedge clk) disable iff (rst)
    (accType > 3'd4) |-> !sfrReq); // R13

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rdValid == 1'b0 && rdData == 8'd0)); // R12

endmodule

bind dspace_router dsr_checks u_checks (
  .clk(clk), .rst(rst), .accType(accType), .addr(addr), .rdEn(rdEn),
  .wrEn(wrEn), .port0In(port0In), .sfrRdData(sfrRdData), .rdData(rdData),
  .rdValid(rdValid), .sfrReq(sfrReq), .sfrWr(sfrWr), .aleOut(aleOut),
  .psenOut(psenOut)
);

// File: tb/dspace_router_bench.sv
module dspace_router_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  accType;
  logic [15:0] addr;
  logic [7:0]  wrData;
  logic        rdEn;
  logic        wrEn;
  logic [1:0]  bankSel;
  logic [7:0]  port0In;
  logic [7:0]  sfrRdData;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        sfrReq;
  logic        sfrWr;
  logic [7:0]  sfrAddr;
  logic [7:0]  sfrWrData;
  logic        aleOut;
  logic        psenOut;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dspace_router u_dspace_router (
    .clk(clk), .rst(rst), .accType(accType), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .wrEn(wrEn), .bankSel(bankSel), .port0In(port0In),
    .sfrRdData(sfrRdData), .rdData(rdData), .rdValid(rdValid),
    .sfrReq(sfrReq), .sfrWr(sfrWr), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .aleOut(aleOut), .psenOut(psenOut)
  );

  // vector: {isWrite, bank[1:0], type[2:0], addr[15:0], data[7:0], reqTag[3:0]}
  localparam int NVEC = 17;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 2'd2, 3'd0, 16'h0005, 8'hA5, 4'd1},  // R1 bank2 R5 -> byte 21
    {1'b0, 2'd0, 3'd1, 16'h0015, 8'hA5, 4'd1},  // R1 read byte 21 directly
    {1'b1, 2'd3, 3'd0, 16'h0007, 8'h11, 4'd1},  // R1 bank3 R7 -> byte 31
    {1'b0, 2'd0, 3'd2, 16'h001F, 8'h11, 4'd1},  // R1
    {1'b1, 2'd0, 3'd1, 16'h0010, 8'h3C, 4'd2},  // R2 direct write
    {1'b0, 2'd0, 3'd2, 16'h0010, 8'h3C, 4'd2},  // R2 indirect read
    {1'b1, 2'd0, 3'd2, 16'h0020, 8'h6E, 4'd2},  // R2 indirect write
    {1'b0, 2'd0, 3'd1, 16'h0020, 8'h6E, 4'd2},  // R2 direct read
    {1'b1, 2'd0, 3'd2, 16'h0090, 8'h77, 4'd3},  // R3 upper RAM
    {1'b0, 2'd0, 3'd2, 16'h0090, 8'h77, 4'd3},  // R3
    {1'b1, 2'd0, 3'd2, 16'h0055, 8'h99, 4'd8},  // R8 internal byte 0x55
    {1'b1, 2'd0, 3'd4, 16'h0155, 8'h5A, 4'd6},  // R6 aux above 255
    {1'b0, 2'd0, 3'd4, 16'h0155, 8'h5A, 4'd6},  // R6
    {1'b1, 2'd0, 3'd3, 16'h0055, 8'hC3, 4'd5},  // R5 8-bit pointer write
    {1'b0, 2'd0, 3'd4, 16'h0055, 8'hC3, 4'd5},  // R5 same byte via 16-bit
    {1'b0, 2'd0, 3'd4, 16'h0155, 8'h5A, 4'd5},  // R5 byte 0x155 untouched
    {1'b0, 2'd0, 3'd2, 16'h0055, 8'h99, 4'd8}   // R8 internal byte intact
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] bk, input logic [2:0] t,
                         input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bankSel = bk; accType = t; addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic doRead(input logic [1:0] bk, input logic [2:0] t,
                        input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bankSel = bk; accType = t; addr = a; rdEn = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    idle();
    check(rdValid === 1'b1, req, int'(rdValid), 1);
    check(rdData === exp, req, int'(rdData), int'(exp));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; accType = 3'd0; addr = '0; wrData = '0; idle();
    bankSel = 2'd0; port0In = 8'h00; sfrRdData = 8'h00;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(rdValid === 1'b0, "R12", int'(rdValid), 0);
    check(rdData === 8'h00, "R12", int'(rdData), 0);
    rst = 1'b0;

    // R9 strobe pins
    check(aleOut === 1'b0, "R9", int'(aleOut), 0);
    check(psenOut === 1'b1, "R9", int'(psenOut), 1);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      if (VEC[i][33])
        doWrite(VEC[i][32:31], VEC[i][30:28], VEC[i][27:12], VEC[i][11:4]);
      else
        doRead(VEC[i][32:31], VEC[i][30:28], VEC[i][27:12], VEC[i][11:4], tag);
    end

    // R10 rdValid drops after the read
    @(negedge clk);
    check(rdValid === 1'b0, "R10", int'(rdValid), 0);

    // R4 / R11 direct SFR read
    @(negedge clk);
    accType = 3'd1; addr = 16'h0090; sfrRdData = 8'hE1; rdEn = 1'b1;
    #1;
    check(sfrReq === 1'b1, "R4", int'(sfrReq), 1);
    check(sfrWr === 1'b0, "R4", int'(sfrWr), 0);
    check(sfrAddr === 8'h90, "R4", int'(sfrAddr), 'h90);
    @(negedge clk);
    idle(); sfrRdData = 8'h00;
    check(rdData === 8'hE1, "R11", int'(rdData), 'hE1);
    check(rdValid === 1'b1, "R11", int'(rdValid), 1);

    // R4 direct SFR write leaves upper RAM intact
    @(negedge clk);
    accType = 3'd1; addr = 16'h0090; wrData = 8'h42; wrEn = 1'b1;
    #1;
    check(sfrReq === 1'b1 && sfrWr === 1'b1, "R4", int'({sfrReq, sfrWr}), 3);
    check(sfrWrData === 8'h42, "R4", int'(sfrWrData), 'h42);
    @(negedge clk);
    idle();
    doRead(2'd0, 3'd2, 16'h0090, 8'h77, "R4 ram untouched");

    // R3 indirect upper access raises no SFR request
    @(negedge clk);
    accType = 3'd2; addr = 16'h0090; rdEn = 1'b1;
    #1;
    check(sfrReq === 1'b0, "R3", int'(sfrReq), 0);
    @(negedge clk);
    idle();

    // R7 off-chip read returns the port, write is dropped
    port0In = 8'h6B;
    doRead(2'd0, 3'd4, 16'h0555, 8'h6B, "R7 port read");
    port0In = 8'h2D;
    doRead(2'd0, 3'd4, 16'hF000, 8'h2D, "R7 port read high");
    doWrite(2'd0, 3'd4, 16'h0555, 8'h00);
    doRead(2'd0, 3'd4, 16'h0155, 8'h5A, "R7 write dropped");

    // R13 unused access types
    doWrite(2'd0, 3'd5, 16'h0010, 8'hFF);
    doWrite(2'd0, 3'd7, 16'h0055, 8'hFF);
    @(negedge clk);
    accType = 3'd6; addr = 16'h0090; rdEn = 1'b1;
    #1;
    check(sfrReq === 1'b0, "R13", int'(sfrReq), 0);
    @(negedge clk);
    idle();
    check(rdValid === 1'b0, "R13", int'(rdValid), 0);
    doRead(2'd0, 3'd2, 16'h0010, 8'h3C, "R13 iram intact");
    doRead(2'd0, 3'd3, 16'h0055, 8'hC3, "R13 xram intact");

    // R9 pins still quiet after all traffic
    check(aleOut === 1'b0 && psenOut === 1'b1, "R9", int'({aleOut, psenOut}), 1);

    // R12 reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rdData === 8'h00 && rdValid === 1'b0, "R12", int'(rdData), 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule